// File: doc/BRIEF.md
# Two-Processor Hardware Lock Bank with Grant Interrupts

This block holds a bank of lock bits shared by two processors, a main CPU and a coprocessor. Each lock bit has at most one owner at a time. A processor asks for locks by writing a one-hot or multi-bit mask to its take register and gives them back by writing a mask to its drop register. The hardware attaches no meaning to any bit; software decides what each lock protects.

A request for a free lock is granted on the next clock edge. A request for a lock held by the other processor is remembered as pending, and ownership passes to the waiting processor on the same edge that processes the owner's drop write. Each processor sees the locks it owns as set bits in its status register. A level interrupt line per processor is raised while any owned lock has its enable bit set.

Each processor has its own register port with combinational read data. Both ports see the same four shared registers. The take and drop registers always act for the port that writes them.

Top module: `hwsem_bank`

## Requirements
- R1: After reset no lock is owned, both status registers and both enable registers read 0, and both interrupt outputs are low.
- R2: Byte addresses on either port decode as follows: 0x00 is the CPU status, 0x04 the CPU enable, 0x08 the coprocessor status, 0x0C the coprocessor enable, 0x10 take and 0x14 drop; the last two act for the writing port. Every other address, including any misaligned one, reads 0 and ignores writes. Read data is combinational.
- R3: A take write sets the status bit of every free lock in its mask; the bit reads 1 from the cycle after the write.
- R4: A take write for a lock owned by the other processor is not granted and stays pending. Ownership passes to the waiting processor on the edge that processes the owner's drop write, so it is visible in the next cycle.
- R5: When both ports take the same free lock in the same cycle, the CPU gets it and the coprocessor request stays pending.
- R6: A drop write by the owner clears that status bit and frees the lock. A drop write by a processor that does not own the lock leaves ownership unchanged, but it cancels that processor's own pending request for the lock.
- R7: Writes to the status addresses have no effect. Zero bits in a take or drop mask leave those locks unchanged.
- R8: Both enable registers are readable and writable from either port. When both ports write the same enable register in one cycle, the CPU port's value is stored.
- R9: Each interrupt output is the level OR over all locks of (that processor's status AND its enable).
- R10: No lock bit is ever set in both status registers at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | CPU port write strobe |
| cpu_addr | input | ADDR_W | CPU port byte address |
| cpu_wdata | input | DATA_W | CPU port write data |
| cpu_rdata | output | DATA_W | CPU port read data (combinational) |
| cop_wr | input | 1 | Coprocessor port write strobe |
| cop_addr | input | ADDR_W | Coprocessor port byte address |
| cop_wdata | input | DATA_W | Coprocessor port write data |
| cop_rdata | output | DATA_W | Coprocessor port read data (combinational) |
| cpu_irq | output | 1 | CPU grant interrupt, level |
| cop_irq | output | 1 | Coprocessor grant interrupt, level |

## Verification
The bench builds the block with its default values: 32 locks, a 32-bit data path and an 8-bit address. This makes the full lock mask and the whole register window, including unmapped and misaligned addresses, reachable. The random phase draws write data mostly from masks of a few low bits. Both processors therefore keep colliding on the same locks, which drives the pending, handoff, tie and cancel paths many times. Directed cases cover each of these orderings once with known values.

// File: rtl/hwsem_pkg.sv
package hwsem_pkg;

    localparam int NUM_MASTERS = 2;
    localparam int M_CPU       = 0;
    localparam int M_COP       = 1;

    // owner of one lock bit
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_CPU  = 2'd1,
        OWN_COP  = 2'd2
    } owner_e;

    // decoded word of the register window
    typedef enum logic [2:0] {
        W_CPU_STAT = 3'd0,
        W_CPU_EN   = 3'd1,
        W_COP_STAT = 3'd2,
        W_COP_EN   = 3'd3,
        W_TAKE     = 3'd4,
        W_DROP     = 3'd5,
        W_NONE     = 3'd7
    } word_e;

    // one port's action in a cycle
    typedef struct packed {
        logic       take;
        logic       drop;
        logic [1:0] en_wr;   // en_wr[m]: write the enable register of master m
    } port_act_t;

    function automatic owner_e owner_code(input int m);
        return (m == M_CPU) ? OWN_CPU : OWN_COP;
    endfunction

    function automatic word_e word_decode(input logic [2:0] idx);
        case (idx)
            3'd0:    return W_CPU_STAT;
            3'd1:    return W_CPU_EN;
            3'd2:    return W_COP_STAT;
            3'd3:    return W_COP_EN;
            3'd4:    return W_TAKE;
            3'd5:    return W_DROP;
            default: return W_NONE;
        endcase
    endfunction

endpackage

// File: rtl/hwsem_port_dec.sv
module hwsem_port_dec
    import hwsem_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output word_e             rsel,
    output port_act_t         act
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    logic              aligned;
    logic              in_range;

    assign widx     = addr[ADDR_W-1:2];
    assign aligned  = (addr[1:0] == 2'b00);
    assign in_range = (widx <= WIDX_W'(5));

    always_comb begin
        if (aligned && in_range) rsel = word_decode(widx[2:0]);
        else                     rsel = W_NONE;
    end

    always_comb begin
        act          = '0;
        act.take     = wr && (rsel == W_TAKE);
        act.drop     = wr && (rsel == W_DROP);
        act.en_wr[M_CPU] = wr && (rsel == W_CPU_EN);
        act.en_wr[M_COP] = wr && (rsel == W_COP_EN);
    end

endmodule

// File: rtl/hwsem_lock_cell.sv
module hwsem_lock_cell
    import hwsem_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_MASTERS-1:0] take,
    input  logic [NUM_MASTERS-1:0] drop,
    output owner_e                 owner_q
);
    logic   [NUM_MASTERS-1:0] pend_q, pend_d;
    logic   [NUM_MASTERS-1:0] owns, want;
    logic                     frees;
    owner_e                   owner_d;

    always_comb begin
        for (int m = 0; m < NUM_MASTERS; m++) begin
            owns[m] = (owner_q == owner_code(m));
            // a drop cancels the same master's waiting request
            want[m] = (pend_q[m] | take[m]) & ~drop[m] & ~owns[m];
        end
        frees = (owner_q == OWN_NONE) | (|(owns & drop));
    end

    always_comb begin
        owner_d = owner_q;
        pend_d  = want;
        if (frees) begin
            if (want[M_CPU]) begin
                owner_d       = OWN_CPU;
                pend_d[M_CPU] = 1'b0;
            end else if (want[M_COP]) begin
                owner_d       = OWN_COP;
                pend_d[M_COP] = 1'b0;
            end else begin
                owner_d = OWN_NONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q <= OWN_NONE;
            pend_q  <= '0;
        end else begin
            owner_q <= owner_d;
            pend_q  <= pend_d;
        end
    end

endmodule

// File: rtl/hwsem_irq_or.sv
module hwsem_irq_or #(
    parameter int N = 32
) (
    input  logic [N-1:0] status,
    input  logic [N-1:0] enable,
    output logic         irq
);
    assign irq = |(status & enable);
endmodule

// File: rtl/hwsem_bank.sv
module hwsem_bank
    import hwsem_pkg::*;
#(
    parameter int NUM_LOCKS = 32,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              cop_wr,
    input  logic [ADDR_W-1:0] cop_addr,
    input  logic [DATA_W-1:0] cop_wdata,
    output logic [DATA_W-1:0] cop_rdata,
    output logic              cpu_irq,
    output logic              cop_irq
);
    localparam int N = NUM_LOCKS;

    logic      [NUM_MASTERS-1:0]             wr_a;
    logic      [NUM_MASTERS-1:0][ADDR_W-1:0] addr_a;
    logic      [NUM_MASTERS-1:0][DATA_W-1:0] wdata_a;
    logic      [NUM_MASTERS-1:0][DATA_W-1:0] rdata_a;
    logic      [NUM_MASTERS-1:0]             irq_a;
    word_e                                   rsel  [NUM_MASTERS];
    port_act_t                               act   [NUM_MASTERS];
    logic      [NUM_MASTERS-1:0][N-1:0]      take_m;
    logic      [NUM_MASTERS-1:0][N-1:0]      drop_m;
    logic      [NUM_MASTERS-1:0][N-1:0]      stat_m;
    logic      [NUM_MASTERS-1:0][N-1:0]      en_q;
    owner_e                                  owner [N];

    assign wr_a[M_CPU]    = cpu_wr;
    assign wr_a[M_COP]    = cop_wr;
    assign addr_a[M_CPU]  = cpu_addr;
    assign addr_a[M_COP]  = cop_addr;
    assign wdata_a[M_CPU] = cpu_wdata;
    assign wdata_a[M_COP] = cop_wdata;
    assign cpu_rdata      = rdata_a[M_CPU];
    assign cop_rdata      = rdata_a[M_COP];
    assign cpu_irq        = irq_a[M_CPU];
    assign cop_irq        = irq_a[M_COP];

    // per-port decode, masks and read mux
    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_port
        hwsem_port_dec #(.ADDR_W(ADDR_W)) u_dec (
            .wr   (wr_a[m]),
            .addr (addr_a[m]),
            .rsel (rsel[m]),
            .act  (act[m])
        );

        assign take_m[m] = act[m].take ? wdata_a[m][N-1:0] : '0;
        assign drop_m[m] = act[m].drop ? wdata_a[m][N-1:0] : '0;

        always_comb begin
            case (rsel[m])
                W_CPU_STAT: rdata_a[m] = DATA_W'(stat_m[M_CPU]);
                W_CPU_EN:   rdata_a[m] = DATA_W'(en_q[M_CPU]);
                W_COP_STAT: rdata_a[m] = DATA_W'(stat_m[M_COP]);
                W_COP_EN:   rdata_a[m] = DATA_W'(en_q[M_COP]);
                default:    rdata_a[m] = '0;
            endcase
        end

        hwsem_irq_or #(.N(N)) u_irq (
            .status (stat_m[m]),
            .enable (en_q[m]),
            .irq    (irq_a[m])
        );
    end

    // one ownership cell per lock bit
    for (genvar i = 0; i < N; i++) begin : g_lock
        hwsem_lock_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .take    ({take_m[M_COP][i], take_m[M_CPU][i]}),
            .drop    ({drop_m[M_COP][i], drop_m[M_CPU][i]}),
            .owner_q (owner[i])
        );
        for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_stat
            assign stat_m[m][i] = (owner[i] == owner_code(m));
        end
    end

    // enable registers; the CPU port wins a same-cycle collision
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else begin
            for (int t = 0; t < NUM_MASTERS; t++) begin
                if (act[M_CPU].en_wr[t])      en_q[t] <= wdata_a[M_CPU][N-1:0];
                else if (act[M_COP].en_wr[t]) en_q[t] <= wdata_a[M_COP][N-1:0];
            end
        end
    end

endmodule

// File: rtl/hwsem_chk.sv
module hwsem_chk #(
    parameter int N = 32
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] take_cpu,
    input logic [N-1:0] take_cop,
    input logic [N-1:0] drop_cpu,
    input logic [N-1:0] drop_cop,
    input logic [N-1:0] stat_cpu,
    input logic [N-1:0] stat_cop,
    input logic [N-1:0] en_cpu,
    input logic [N-1:0] en_cop,
    input logic         cpu_irq,
    input logic         cop_irq
);
    // R3: free locks taken by the CPU are owned by it next cycle
    a_r3_free_grant: assert property (@(posedge clk) disable iff (rst)
        (|(take_cpu & ~stat_cpu & ~stat_cop)) |=>
        ((stat_cpu & $past(take_cpu & ~stat_cpu & ~stat_cop)) ==
         $past(take_cpu & ~stat_cpu & ~stat_cop)));

    // R5: in a same-cycle tie on a free lock the coprocessor does not get it
    a_r5_cpu_priority: assert property (@(posedge clk) disable iff (rst)
        (|(take_cpu & take_cop & ~stat_cpu & ~stat_cop)) |=>
        ((stat_cop & $past(take_cpu & take_cop & ~stat_cpu & ~stat_cop)) == '0));

    // R6: owner's drop clears its status
    a_r6_drop_clears: assert property (@(posedge clk) disable iff (rst)
        (|(drop_cpu & stat_cpu)) |=>
        ((stat_cpu & $past(drop_cpu & stat_cpu)) == '0));

    // R4, R6: a lock stays with its owner until the owner drops it
    a_r4_owner_keeps: assert property (@(posedge clk) disable iff (rst)
        (|(stat_cop & ~drop_cop)) |=>
        ((stat_cop & $past(stat_cop & ~drop_cop)) == $past(stat_cop & ~drop_cop)));

    // R9: no interrupt without an enable or without an owned lock
    a_r9_cpu_gate: assert property (@(posedge clk) disable iff (rst)
        (en_cpu == '0) |-> !cpu_irq);
    a_r9_cop_gate: assert property (@(posedge clk) disable iff (rst)
        (stat_cop == '0) |-> !cop_irq);

    // R10: grant to the CPU never lands on a lock the coprocessor keeps
    a_r10_no_double: assert property (@(posedge clk) disable iff (rst)
        (|(stat_cop & ~drop_cop)) |=>
        ((stat_cpu & $past(stat_cop & ~drop_cop)) == '0));

endmodule

bind hwsem_bank hwsem_chk #(.N(NUM_LOCKS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .take_cpu (take_m[0]),
    .take_cop (take_m[1]),
    .drop_cpu (drop_m[0]),
    .drop_cop (drop_m[1]),
    .stat_cpu (stat_m[0]),
    .stat_cop (stat_m[1]),
    .en_cpu   (en_q[0]),
    .en_cop   (en_q[1]),
    .cpu_irq  (cpu_irq),
    .cop_irq  (cop_irq)
);

// File: tb/hwsem_bank_bench.sv
module hwsem_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 32;
    localparam int DW = 32;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_wr = 1'b0, cop_wr = 1'b0;
    logic [AW-1:0] cpu_addr = '0, cop_addr = '0;
    logic [DW-1:0] cpu_wdata = '0, cop_wdata = '0;
    logic [DW-1:0] cpu_rdata, cop_rdata;
    logic          cpu_irq, cop_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model: 0 free, 1 CPU, 2 coprocessor
    int            mown [N];
    bit   [N-1:0]  mpend [2];
    logic [DW-1:0] men [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    hwsem_bank #(.NUM_LOCKS(N), .DATA_W(DW), .ADDR_W(AW)) u_hwsem_bank (
        .clk(clk), .rst(rst),
        .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cop_wr(cop_wr), .cop_addr(cop_addr), .cop_wdata(cop_wdata), .cop_rdata(cop_rdata),
        .cpu_irq(cpu_irq), .cop_irq(cop_irq)
    );

    function automatic logic [DW-1:0] exp_stat(input int who);
        logic [DW-1:0] v = '0;
        for (int i = 0; i < N; i++) if (mown[i] == who) v[i] = 1'b1;
        return v;
    endfunction

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
        case (a)
            8'h00:   return exp_stat(1);
            8'h04:   return men[0];
            8'h08:   return exp_stat(2);
            8'h0C:   return men[1];
            default: return '0;
        endcase
    endfunction

    function automatic logic [DW-1:0] mask_of(input bit w, input logic [AW-1:0] a,
                                              input logic [AW-1:0] want,
                                              input logic [DW-1:0] d);
        return (w && a == want) ? d : '0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) mown[i] = 0;
        mpend[0] = '0; mpend[1] = '0;
        men[0] = '0; men[1] = '0;
    endtask

    task automatic model_step(input bit cw, input logic [AW-1:0] ca, input logic [DW-1:0] cd,
                              input bit pw, input logic [AW-1:0] pa, input logic [DW-1:0] pd);
        logic [DW-1:0] tk [2];
        logic [DW-1:0] dr [2];
        int            nown [N];
        bit   [N-1:0]  npend [2];
        tk[0] = mask_of(cw, ca, 8'h10, cd); tk[1] = mask_of(pw, pa, 8'h10, pd);
        dr[0] = mask_of(cw, ca, 8'h14, cd); dr[1] = mask_of(pw, pa, 8'h14, pd);
        for (int i = 0; i < N; i++) begin
            bit req0, req1, avail;
            req0 = (mpend[0][i] || tk[0][i]) && !dr[0][i] && mown[i] != 1;
            req1 = (mpend[1][i] || tk[1][i]) && !dr[1][i] && mown[i] != 2;
            avail = (mown[i] == 0) || (mown[i] == 1 && dr[0][i]) || (mown[i] == 2 && dr[1][i]);
            nown[i] = mown[i];
            npend[0][i] = req0; npend[1][i] = req1;
            if (avail) begin
                if (req0)      begin nown[i] = 1; npend[0][i] = 1'b0; end
                else if (req1) begin nown[i] = 2; npend[1][i] = 1'b0; end
                else           nown[i] = 0;
            end
        end
        for (int i = 0; i < N; i++) mown[i] = nown[i];
        mpend[0] = npend[0]; mpend[1] = npend[1];
        if (cw && ca == 8'h04) men[0] = cd; else if (pw && pa == 8'h04) men[0] = pd;
        if (cw && ca == 8'h0C) men[1] = cd; else if (pw && pa == 8'h0C) men[1] = pd;
    endtask

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // called just after a rising edge: drive, advance one edge, release strobes
    task automatic step(input bit cw, input logic [AW-1:0] ca, input logic [DW-1:0] cd,
                        input bit pw, input logic [AW-1:0] pa, input logic [DW-1:0] pd);
        cpu_wr = cw; cpu_addr = ca; cpu_wdata = cd;
        cop_wr = pw; cop_addr = pa; cop_wdata = pd;
        model_step(cw, ca, cd, pw, pa, pd);
        @(posedge clk); #1;
        cpu_wr = 1'b0; cop_wr = 1'b0;
    endtask

    task automatic rd(input bit cop_port, input logic [AW-1:0] a, output logic [DW-1:0] v);
        if (cop_port) begin cop_addr = a; #1; v = cop_rdata; end
        else          begin cpu_addr = a; #1; v = cpu_rdata; end
    endtask

    task automatic check_regs(input string tag);
        logic [DW-1:0] s0, s1, v;
        rd(0, 8'h00, s0); check({tag, " cpu status"}, s0, exp_read(8'h00));
        rd(1, 8'h04, v);  check({tag, " cpu enable"}, v, exp_read(8'h04));
        rd(1, 8'h08, s1); check({tag, " cop status"}, s1, exp_read(8'h08));
        rd(0, 8'h0C, v);  check({tag, " cop enable"}, v, exp_read(8'h0C));
        check({tag, " R10 exclusive"}, s0 & s1, '0);
        check({tag, " R9 cpu irq"}, DW'(cpu_irq), DW'(|(exp_stat(1) & men[0])));
        check({tag, " R9 cop irq"}, DW'(cop_irq), DW'(|(exp_stat(2) & men[1])));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] v;
        logic [AW-1:0] addrs [7];
        logic [DW-1:0] masks [4];
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;

        check_regs("R1 reset");
        check("R1 cpu irq low", DW'(cpu_irq), '0);

        // R3: free lock granted next cycle
        step(1, 8'h10, 32'h1, 0, 8'h00, 0);
        rd(0, 8'h00, v); check("R3 cpu takes bit0", v, 32'h1);
        // R4: coprocessor waits
        step(0, 8'h00, 0, 1, 8'h10, 32'h1);
        rd(1, 8'h08, v); check("R4 cop pending not granted", v, 32'h0);
        // R4/R6: owner drops, waiting side gets it
        step(1, 8'h14, 32'h1, 0, 8'h00, 0);
        rd(1, 8'h08, v); check("R4 handoff to cop", v, 32'h1);
        rd(0, 8'h00, v); check("R6 cpu released", v, 32'h0);
        // R6: drop by non-owner ignored
        step(1, 8'h14, 32'h1, 0, 8'h00, 0);
        rd(1, 8'h08, v); check("R6 non-owner drop ignored", v, 32'h1);
        // R5: tie on a free lock
        step(1, 8'h10, 32'h4, 1, 8'h10, 32'h4);
        rd(0, 8'h00, v); check("R5 cpu wins tie", v, 32'h4);
        rd(1, 8'h08, v); check("R5 cop loses tie", v, 32'h1);
        step(1, 8'h14, 32'h4, 0, 8'h00, 0);
        rd(1, 8'h08, v); check("R5 cop granted after cpu drop", v, 32'h5);
        // R6: pending cancelled by own drop
        step(1, 8'h10, 32'h1, 0, 8'h00, 0);
        step(1, 8'h14, 32'h1, 0, 8'h00, 0);
        step(0, 8'h00, 0, 1, 8'h14, 32'h1);
        rd(0, 8'h00, v); check("R6 cancelled pending not granted", v, 32'h0);
        rd(1, 8'h08, v); check("R6 cop dropped bit0", v, 32'h4);
        // R7: status read-only, zero masks inert
        step(1, 8'h00, 32'hFFFF_FFFF, 1, 8'h08, 32'hFFFF_FFFF);
        step(1, 8'h10, 32'h0, 1, 8'h14, 32'h0);
        check_regs("R7 status writes and zero masks");
        rd(1, 8'h08, v); check("R7 cop status unchanged", v, 32'h4);
        // R8/R9: enables and interrupts
        step(1, 8'h0C, 32'h4, 0, 8'h00, 0);
        check("R9 cop irq raised", DW'(cop_irq), 32'h1);
        check("R9 cpu irq low", DW'(cpu_irq), 32'h0);
        step(1, 8'h0C, 32'h8, 1, 8'h0C, 32'h4);
        rd(1, 8'h0C, v); check("R8 cpu port wins enable write", v, 32'h8);
        check("R9 cop irq dropped", DW'(cop_irq), 32'h0);
        // R2: unmapped and misaligned addresses
        step(1, 8'h11, 32'h2, 0, 8'h00, 0);
        rd(0, 8'h00, v); check("R2 misaligned take ignored", v, 32'h0);
        rd(0, 8'h18, v); check("R2 unmapped reads zero", v, 32'h0);
        rd(1, 8'h10, v); check("R2 take reads zero", v, 32'h0);
        check_regs("R2 map");

        addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18};
        masks = '{32'h0000_000F, 32'h0000_0003, 32'hFFFF_FFFF, 32'h0000_0001};
        for (int it = 0; it < 600; it++) begin
            bit            cw, pw;
            logic [AW-1:0] ca, pa;
            logic [DW-1:0] cd, pd;
            cw = ($urandom % 5) != 0;
            pw = ($urandom % 5) != 0;
            ca = addrs[($urandom % 10) < 6 ? 4 + ($urandom % 2) : $urandom % 7];
            pa = addrs[($urandom % 10) < 6 ? 4 + ($urandom % 2) : $urandom % 7];
            cd = $urandom & masks[$urandom % 4];
            pd = $urandom & masks[$urandom % 4];
            step(cw, ca, cd, pw, pa, pd);
            check_regs("R10 random");
        end
        finish_run();
    end
endmodule